// File: doc/BRIEF.md
# Address-Space-Tagged Associative Translation Buffer

This block caches virtual-to-physical page translations in a small, fully associative array. Each slot stores a virtual page number tag, a physical page number, an address-space number, a global flag, per-privilege-mode read and write enables, and two fault-on-access flags. A lookup is purely combinational. It takes a virtual address and the current address-space number and returns a hit flag, the index of the matching slot, the physical address, and the stored attribute bits. The permission decision is left to the consumer.

Pages are 8 KB. The page number is therefore the virtual address from bit 13 upward, and the low 13 bits pass straight through as the page offset. New translations go into the slot named by a rotating victim pointer. Three kinds of invalidation are supported: every slot, every non-global slot, and the slots matching one page number within one address space. At most one state-changing operation takes effect per clock cycle. When several requests arrive together, a fixed priority among them decides which one runs.

Top module: `asid_tlb`

## Requirements
- R1: A lookup hits only on a valid slot whose tag equals `lk_va[VA_W-1:13]` and whose global bit is 1 or whose address-space number equals `lk_asn`. On a miss, `hit` is 0 and every `hit_*` output is 0.
- R2: On a hit, `hit_pa` equals the slot's physical page number concatenated above `lk_va[12:0]`. `hit_idx`, `hit_global`, `hit_asn`, `hit_rd_en`, `hit_wr_en`, `hit_fault_rd` and `hit_fault_wr` show that slot's stored values.
- R3: An insert writes the slot at the victim pointer in the next clock edge, overwriting whatever it held. It sets the tag to `op_va[VA_W-1:13]`, marks the slot valid, and advances the pointer by one.
- R4: Invalidate-all clears every slot's valid bit and returns the victim pointer to 0.
- R5: Invalidate-non-global clears every slot whose global bit is 0 and leaves global slots untouched.
- R6: Invalidate-single clears every valid slot that would hit a lookup of `op_va`/`op_asn` under the R1 rule, duplicates included. When no slot matches, it changes nothing.
- R7: The victim pointer wraps from DEPTH-1 to 0, so the (DEPTH+1)-th insert after a flush overwrites slot 0.
- R8: When several slots match a lookup, the lowest-indexed one is reported.
- R9: Only one operation is applied per cycle, in this priority order: invalidate-all, then invalidate-non-global, then invalidate-single, then insert. A lower-priority request in the same cycle is dropped.
- R10: After reset every slot is invalid and the victim pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_va | input | VA_W | Lookup virtual address |
| lk_asn | input | ASN_W | Lookup address-space number |
| ins_req | input | 1 | Insert request |
| flush_one_req | input | 1 | Invalidate-single request |
| flush_ng_req | input | 1 | Invalidate-non-global request |
| flush_all_req | input | 1 | Invalidate-all request |
| op_va | input | VA_W | Virtual address for insert or invalidate-single |
| op_asn | input | ASN_W | Address-space number for insert or invalidate-single |
| ins_ppn | input | PPN_W | Physical page number to insert |
| ins_global | input | 1 | Global flag to insert |
| ins_rd_en | input | NMODES | Per-mode read enables to insert |
| ins_wr_en | input | NMODES | Per-mode write enables to insert |
| ins_fault_rd | input | 1 | Fault-on-read flag to insert |
| ins_fault_wr | input | 1 | Fault-on-write flag to insert |
| hit | output | 1 | Lookup hit |
| hit_idx | output | IDX_W | Index of the reported slot |
| hit_pa | output | PPN_W+13 | Translated physical address |
| hit_global | output | 1 | Global flag of the reported slot |
| hit_asn | output | ASN_W | Address-space number of the reported slot |
| hit_rd_en | output | NMODES | Read enables of the reported slot |
| hit_wr_en | output | NMODES | Write enables of the reported slot |
| hit_fault_rd | output | 1 | Fault-on-read flag of the reported slot |
| hit_fault_wr | output | 1 | Fault-on-write flag of the reported slot |

## Verification
The assertions assume that request inputs are stable around the rising clock edge and that a lookup's result is read in the same cycle its address is applied. The bench honours both. It changes every input on the falling edge and samples outputs a little after. The assertions also expect DEPTH to be a power of two or smaller than the pointer range, so that the wrap comparison is exact. The bench runs with the default depth of 64. Duplicate tags are created on purpose only in the scenario that checks lowest-index selection and multi-slot invalidation.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;

    // Operation applied to the slot array in a given cycle.
    typedef enum logic [2:0] {
        OP_IDLE      = 3'd0,
        OP_INSERT    = 3'd1,
        OP_FLUSH_ONE = 3'd2,
        OP_FLUSH_NG  = 3'd3,
        OP_FLUSH_ALL = 3'd4
    } tlb_op_e;

endpackage

// File: rtl/tlb_op_arbiter.sv
module tlb_op_arbiter
    import asid_tlb_pkg::*;
(
    input  logic    ins_req,
    input  logic    flush_one_req,
    input  logic    flush_ng_req,
    input  logic    flush_all_req,
    output tlb_op_e op
);

    // Fixed priority: broader invalidations win over narrower ones, and all win over insert.
    always_comb begin
        if (flush_all_req)      op = OP_FLUSH_ALL;
        else if (flush_ng_req)  op = OP_FLUSH_NG;
        else if (flush_one_req) op = OP_FLUSH_ONE;
        else if (ins_req)       op = OP_INSERT;
        else                    op = OP_IDLE;
    end

endmodule

// File: rtl/tlb_victim_ptr.sv
module tlb_victim_ptr
    import asid_tlb_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tlb_op_e          op,
    output logic [IDX_W-1:0] ptr
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    logic [IDX_W-1:0] ptr_nxt;

    always_comb begin
        ptr_nxt = ptr;
        unique case (op)
            OP_FLUSH_ALL: ptr_nxt = '0;
            OP_INSERT:    ptr_nxt = (ptr == LAST) ? '0 : ptr + 1'b1;
            OP_IDLE, OP_FLUSH_ONE, OP_FLUSH_NG: ptr_nxt = ptr;
            default:      ptr_nxt = ptr;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr <= '0;
        else        ptr <= ptr_nxt;
    end

endmodule

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
    import asid_tlb_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int IDX_W  = $clog2(DEPTH),
    parameter int VPN_W  = 30,
    parameter int PPN_W  = 28,
    parameter int ASN_W  = 8,
    parameter int NMODES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tlb_op_e           op,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VPN_W-1:0]  op_vpn,
    input  logic [ASN_W-1:0]  op_asn,
    input  logic [PPN_W-1:0]  ins_ppn,
    input  logic              ins_global,
    input  logic [NMODES-1:0] ins_rd_en,
    input  logic [NMODES-1:0] ins_wr_en,
    input  logic              ins_fault_rd,
    input  logic              ins_fault_wr,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASN_W-1:0]  lk_asn,
    output logic [DEPTH-1:0]  valid_vec,
    output logic [DEPTH-1:0]  glob_vec,
    output logic [DEPTH-1:0]  lk_match,
    output logic [PPN_W-1:0]  ppn_arr   [DEPTH],
    output logic [ASN_W-1:0]  asn_arr   [DEPTH],
    output logic [NMODES-1:0] rd_arr    [DEPTH],
    output logic [NMODES-1:0] wr_arr    [DEPTH],
    output logic [DEPTH-1:0]  frd_vec,
    output logic [DEPTH-1:0]  fwr_vec
);

    logic [VPN_W-1:0] tag_arr [DEPTH];
    logic [DEPTH-1:0] fl_match;

    // Per-slot comparators: one for the lookup port, one for invalidate-single.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign lk_match[g] = valid_vec[g] && (tag_arr[g] == lk_vpn)
                           && (glob_vec[g] || (asn_arr[g] == lk_asn));
        assign fl_match[g] = valid_vec[g] && (tag_arr[g] == op_vpn)
                           && (glob_vec[g] || (asn_arr[g] == op_asn));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_vec <= '0;
            glob_vec  <= '0;
            frd_vec   <= '0;
            fwr_vec   <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                tag_arr[i] <= '0;
                ppn_arr[i] <= '0;
                asn_arr[i] <= '0;
                rd_arr[i]  <= '0;
                wr_arr[i]  <= '0;
            end
        end else begin
            unique case (op)
                OP_INSERT: begin
                    valid_vec[wr_idx] <= 1'b1;
                    glob_vec[wr_idx]  <= ins_global;
                    frd_vec[wr_idx]   <= ins_fault_rd;
                    fwr_vec[wr_idx]   <= ins_fault_wr;
                    tag_arr[wr_idx]   <= op_vpn;
                    ppn_arr[wr_idx]   <= ins_ppn;
                    asn_arr[wr_idx]   <= op_asn;
                    rd_arr[wr_idx]    <= ins_rd_en;
                    wr_arr[wr_idx]    <= ins_wr_en;
                end
                OP_FLUSH_ONE: valid_vec <= valid_vec & ~fl_match;
                OP_FLUSH_NG:  valid_vec <= valid_vec & glob_vec;
                OP_FLUSH_ALL: valid_vec <= '0;
                OP_IDLE:      valid_vec <= valid_vec;
                default:      valid_vec <= valid_vec;
            endcase
        end
    end

endmodule

// File: rtl/tlb_hit_select.sv
module tlb_hit_select #(
    parameter int DEPTH  = 64,
    parameter int IDX_W  = $clog2(DEPTH),
    parameter int PPN_W  = 28,
    parameter int ASN_W  = 8,
    parameter int NMODES = 4
) (
    input  logic [DEPTH-1:0]  lk_match,
    input  logic [DEPTH-1:0]  glob_vec,
    input  logic [PPN_W-1:0]  ppn_arr [DEPTH],
    input  logic [ASN_W-1:0]  asn_arr [DEPTH],
    input  logic [NMODES-1:0] rd_arr  [DEPTH],
    input  logic [NMODES-1:0] wr_arr  [DEPTH],
    input  logic [DEPTH-1:0]  frd_vec,
    input  logic [DEPTH-1:0]  fwr_vec,
    output logic              hit,
    output logic [IDX_W-1:0]  hit_idx,
    output logic [PPN_W-1:0]  hit_ppn,
    output logic              hit_global,
    output logic [ASN_W-1:0]  hit_asn,
    output logic [NMODES-1:0] hit_rd_en,
    output logic [NMODES-1:0] hit_wr_en,
    output logic              hit_fault_rd,
    output logic              hit_fault_wr
);

    logic [IDX_W-1:0] sel;
    logic             found;

    // Scan downward so the last assignment is the lowest matching index.
    always_comb begin
        sel   = '0;
        found = 1'b0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (lk_match[i]) begin
                sel   = IDX_W'(i);
                found = 1'b1;
            end
        end
    end

    always_comb begin
        hit          = found;
        hit_idx      = '0;
        hit_ppn      = '0;
        hit_global   = 1'b0;
        hit_asn      = '0;
        hit_rd_en    = '0;
        hit_wr_en    = '0;
        hit_fault_rd = 1'b0;
        hit_fault_wr = 1'b0;
        if (found) begin
            hit_idx      = sel;
            hit_ppn      = ppn_arr[sel];
            hit_global   = glob_vec[sel];
            hit_asn      = asn_arr[sel];
            hit_rd_en    = rd_arr[sel];
            hit_wr_en    = wr_arr[sel];
            hit_fault_rd = frd_vec[sel];
            hit_fault_wr = fwr_vec[sel];
        end
    end

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
    import asid_tlb_pkg::*;
#(
    parameter int DEPTH     = 64,
    parameter int VA_W      = 43,
    parameter int PAGE_BITS = 13,
    parameter int PPN_W     = 28,
    parameter int ASN_W     = 8,
    parameter int NMODES    = 4,
    parameter int IDX_W     = $clog2(DEPTH),
    parameter int VPN_W     = VA_W - PAGE_BITS,
    parameter int PA_W      = PPN_W + PAGE_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VA_W-1:0]   lk_va,
    input  logic [ASN_W-1:0]  lk_asn,
    input  logic              ins_req,
    input  logic              flush_one_req,
    input  logic              flush_ng_req,
    input  logic              flush_all_req,
    input  logic [VA_W-1:0]   op_va,
    input  logic [ASN_W-1:0]  op_asn,
    input  logic [PPN_W-1:0]  ins_ppn,
    input  logic              ins_global,
    input  logic [NMODES-1:0] ins_rd_en,
    input  logic [NMODES-1:0] ins_wr_en,
    input  logic              ins_fault_rd,
    input  logic              ins_fault_wr,
    output logic              hit,
    output logic [IDX_W-1:0]  hit_idx,
    output logic [PA_W-1:0]   hit_pa,
    output logic              hit_global,
    output logic [ASN_W-1:0]  hit_asn,
    output logic [NMODES-1:0] hit_rd_en,
    output logic [NMODES-1:0] hit_wr_en,
    output logic              hit_fault_rd,
    output logic              hit_fault_wr
);

    tlb_op_e          op_sel;
    logic [IDX_W-1:0] victim;
    logic [DEPTH-1:0] valid_vec;
    logic [DEPTH-1:0] glob_vec;
    logic [DEPTH-1:0] lk_match;
    logic [DEPTH-1:0] frd_vec;
    logic [DEPTH-1:0] fwr_vec;
    logic [PPN_W-1:0]  ppn_arr [DEPTH];
    logic [ASN_W-1:0]  asn_arr [DEPTH];
    logic [NMODES-1:0] rd_arr  [DEPTH];
    logic [NMODES-1:0] wr_arr  [DEPTH];
    logic [PPN_W-1:0]  sel_ppn;

    tlb_op_arbiter u_arb (
        .ins_req       (ins_req),
        .flush_one_req (flush_one_req),
        .flush_ng_req  (flush_ng_req),
        .flush_all_req (flush_all_req),
        .op            (op_sel)
    );

    tlb_victim_ptr #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (op_sel),
        .ptr   (victim)
    );

    tlb_entry_store #(
        .DEPTH(DEPTH), .IDX_W(IDX_W), .VPN_W(VPN_W),
        .PPN_W(PPN_W), .ASN_W(ASN_W), .NMODES(NMODES)
    ) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .op           (op_sel),
        .wr_idx       (victim),
        .op_vpn       (op_va[VA_W-1:PAGE_BITS]),
        .op_asn       (op_asn),
        .ins_ppn      (ins_ppn),
        .ins_global   (ins_global),
        .ins_rd_en    (ins_rd_en),
        .ins_wr_en    (ins_wr_en),
        .ins_fault_rd (ins_fault_rd),
        .ins_fault_wr (ins_fault_wr),
        .lk_vpn       (lk_va[VA_W-1:PAGE_BITS]),
        .lk_asn       (lk_asn),
        .valid_vec    (valid_vec),
        .glob_vec     (glob_vec),
        .lk_match     (lk_match),
        .ppn_arr      (ppn_arr),
        .asn_arr      (asn_arr),
        .rd_arr       (rd_arr),
        .wr_arr       (wr_arr),
        .frd_vec      (frd_vec),
        .fwr_vec      (fwr_vec)
    );

    tlb_hit_select #(
        .DEPTH(DEPTH), .IDX_W(IDX_W), .PPN_W(PPN_W),
        .ASN_W(ASN_W), .NMODES(NMODES)
    ) u_sel (
        .lk_match     (lk_match),
        .glob_vec     (glob_vec),
        .ppn_arr      (ppn_arr),
        .asn_arr      (asn_arr),
        .rd_arr       (rd_arr),
        .wr_arr       (wr_arr),
        .frd_vec      (frd_vec),
        .fwr_vec      (fwr_vec),
        .hit          (hit),
        .hit_idx      (hit_idx),
        .hit_ppn      (sel_ppn),
        .hit_global   (hit_global),
        .hit_asn      (hit_asn),
        .hit_rd_en    (hit_rd_en),
        .hit_wr_en    (hit_wr_en),
        .hit_fault_rd (hit_fault_rd),
        .hit_fault_wr (hit_fault_wr)
    );

    assign hit_pa = hit ? {sel_ppn, lk_va[PAGE_BITS-1:0]} : '0;

endmodule

// File: rtl/asid_tlb_checker.sv
module asid_tlb_checker
    import asid_tlb_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst_n,
    input tlb_op_e          op,
    input logic [IDX_W-1:0] ptr,
    input logic [DEPTH-1:0] valid_vec,
    input logic [DEPTH-1:0] glob_vec,
    input logic [DEPTH-1:0] match_vec,
    input logic             hit,
    input logic [IDX_W-1:0] hit_idx
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    logic [DEPTH-1:0] below_mask;
    assign below_mask = (DEPTH'(1) << hit_idx) - DEPTH'(1);

    AST_MATCH_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (match_vec & ~valid_vec) == '0);                                   // R1
    AST_MISS_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> match_vec == '0);                                         // R1
    AST_HIT_IS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> match_vec[hit_idx]);                                       // R2
    AST_HIT_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (match_vec & below_mask) == '0);                           // R8
    AST_INSERT_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_INSERT |=> valid_vec[$past(ptr)]);                        // R3
    AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_INSERT && ptr != LAST) |=> ptr == $past(ptr) + 1'b1);    // R3
    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_INSERT && ptr == LAST) |=> ptr == '0);                   // R7
    AST_FLUSH_ALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_FLUSH_ALL |=> (valid_vec == '0) && (ptr == '0));          // R4
    AST_FLUSH_NG_KEEPS_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_FLUSH_NG |=> ((valid_vec & ~glob_vec) == '0)
            && ((valid_vec & glob_vec) == $past(valid_vec & glob_vec)));   // R5
    AST_FLUSH_ONE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_FLUSH_ONE |=> (valid_vec & ~$past(valid_vec)) == '0);     // R6
    AST_FLUSH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        op != OP_INSERT |=> ptr == '0 || $stable(ptr));                    // R9

endmodule

bind asid_tlb asid_tlb_checker #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (op_sel),
    .ptr       (victim),
    .valid_vec (valid_vec),
    .glob_vec  (glob_vec),
    .match_vec (lk_match),
    .hit       (hit),
    .hit_idx   (hit_idx)
);

// File: tb/asid_tlb_tb_top.sv
`timescale 1ns/1ps
module asid_tlb_tb_top;

    localparam int DEPTH = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [42:0] lk_va = '0;
    logic [7:0]  lk_asn = '0;
    logic        ins_req = 1'b0, flush_one_req = 1'b0, flush_ng_req = 1'b0, flush_all_req = 1'b0;
    logic [42:0] op_va = '0;
    logic [7:0]  op_asn = '0;
    logic [27:0] ins_ppn = '0;
    logic        ins_global = 1'b0;
    logic [3:0]  ins_rd_en = '0, ins_wr_en = '0;
    logic        ins_fault_rd = 1'b0, ins_fault_wr = 1'b0;
    logic        hit;
    logic [5:0]  hit_idx;
    logic [40:0] hit_pa;
    logic        hit_global;
    logic [7:0]  hit_asn;
    logic [3:0]  hit_rd_en, hit_wr_en;
    logic        hit_fault_rd, hit_fault_wr;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    asid_tlb dut_i (
        .clk(clk), .rst_n(rst_n), .lk_va(lk_va), .lk_asn(lk_asn),
        .ins_req(ins_req), .flush_one_req(flush_one_req),
        .flush_ng_req(flush_ng_req), .flush_all_req(flush_all_req),
        .op_va(op_va), .op_asn(op_asn), .ins_ppn(ins_ppn), .ins_global(ins_global),
        .ins_rd_en(ins_rd_en), .ins_wr_en(ins_wr_en),
        .ins_fault_rd(ins_fault_rd), .ins_fault_wr(ins_fault_wr),
        .hit(hit), .hit_idx(hit_idx), .hit_pa(hit_pa), .hit_global(hit_global),
        .hit_asn(hit_asn), .hit_rd_en(hit_rd_en), .hit_wr_en(hit_wr_en),
        .hit_fault_rd(hit_fault_rd), .hit_fault_wr(hit_fault_wr)
    );

    function automatic logic [42:0] mkva(input logic [29:0] vpn, input logic [12:0] off);
        return {vpn, off};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic look(input logic [29:0] vpn, input logic [12:0] off, input logic [7:0] asn);
        lk_va  = mkva(vpn, off);
        lk_asn = asn;
        #1;
    endtask

    task automatic expect_hit(input string req, input logic [29:0] vpn, input logic [7:0] asn,
                              input logic [5:0] idx, input logic [27:0] ppn);
        look(vpn, 13'h0A5, asn);
        check(req, 64'(hit), 64'd1);
        check(req, 64'(hit_idx), 64'(idx));
        check(req, 64'(hit_pa), 64'({ppn, 13'h0A5}));
    endtask

    task automatic expect_miss(input string req, input logic [29:0] vpn, input logic [7:0] asn);
        look(vpn, 13'h1234, asn);
        check(req, 64'(hit), 64'd0);
        check(req, 64'(hit_pa), 64'd0);
    endtask

    // Drives one cycle of requests, applied at the next rising edge.
    task automatic step(input logic ins, input logic f1, input logic fng, input logic fall,
                        input logic [29:0] vpn, input logic [7:0] asn, input logic [27:0] ppn,
                        input logic g);
        @(negedge clk);
        ins_req = ins; flush_one_req = f1; flush_ng_req = fng; flush_all_req = fall;
        op_va = mkva(vpn, 13'h1FFF); op_asn = asn; ins_ppn = ppn; ins_global = g;
        ins_rd_en = 4'b0101; ins_wr_en = 4'b0001; ins_fault_rd = 1'b0; ins_fault_wr = 1'b1;
        @(negedge clk);
        ins_req = 1'b0; flush_one_req = 1'b0; flush_ng_req = 1'b0; flush_all_req = 1'b0;
    endtask

    task automatic insert(input logic [29:0] vpn, input logic [7:0] asn, input logic [27:0] ppn,
                          input logic g);
        step(1'b1, 1'b0, 1'b0, 1'b0, vpn, asn, ppn, g);
    endtask

    task automatic t_reset();
        expect_miss("R10 reset empty", 30'h0, 8'h0);
        expect_miss("R10 reset empty", 30'h5, 8'h3);
        insert(30'h77, 8'h1, 28'h99, 1'b0);
        expect_hit("R10 first insert lands at 0", 30'h77, 8'h1, 6'd0, 28'h99);
        step(1'b0, 1'b0, 1'b0, 1'b1, 30'h0, 8'h0, 28'h0, 1'b0);
    endtask

    task automatic t_basic();
        @(negedge clk);
        ins_req = 1'b1; op_va = mkva(30'h5, 13'h0ABC); op_asn = 8'h3; ins_ppn = 28'h123;
        ins_global = 1'b0; ins_rd_en = 4'b0011; ins_wr_en = 4'b1000;
        ins_fault_rd = 1'b1; ins_fault_wr = 1'b0;
        @(negedge clk);
        ins_req = 1'b0;
        look(30'h5, 13'h1F0F, 8'h3);
        check("R1 hit same asn", 64'(hit), 64'd1);
        check("R2 pa concat", 64'(hit_pa), 64'({28'h123, 13'h1F0F}));
        check("R2 idx", 64'(hit_idx), 64'd0);
        check("R2 asn", 64'(hit_asn), 64'h3);
        check("R2 global", 64'(hit_global), 64'd0);
        check("R2 rd_en", 64'(hit_rd_en), 64'h3);
        check("R2 wr_en", 64'(hit_wr_en), 64'h8);
        check("R2 fault_rd", 64'(hit_fault_rd), 64'd1);
        check("R2 fault_wr", 64'(hit_fault_wr), 64'd0);
        expect_miss("R1 other asn misses", 30'h5, 8'h4);
        expect_miss("R1 other vpn misses", 30'h6, 8'h3);
    endtask

    task automatic t_global();
        insert(30'h9, 8'h1, 28'h77, 1'b1);
        expect_hit("R1 R3 global any asn", 30'h9, 8'hEE, 6'd1, 28'h77);
        check("R2 global flag", 64'(hit_global), 64'd1);
    endtask

    task automatic t_dup();
        insert(30'h5, 8'h3, 28'h456, 1'b0);
        expect_hit("R8 lowest index wins", 30'h5, 8'h3, 6'd0, 28'h123);
    endtask

    task automatic t_flush_one();
        step(1'b0, 1'b1, 1'b0, 1'b0, 30'h5, 8'h7, 28'h0, 1'b0);
        expect_hit("R6 no match no effect", 30'h5, 8'h3, 6'd0, 28'h123);
        step(1'b0, 1'b1, 1'b0, 1'b0, 30'h5, 8'h3, 28'h0, 1'b0);
        expect_miss("R6 all duplicates cleared", 30'h5, 8'h3);
        expect_hit("R6 unrelated kept", 30'h9, 8'h1, 6'd1, 28'h77);
        step(1'b0, 1'b1, 1'b0, 1'b0, 30'h9, 8'h42, 28'h0, 1'b0);
        expect_miss("R6 global matched any asn", 30'h9, 8'h1);
    endtask

    task automatic t_flush_ng();
        insert(30'h20, 8'h2, 28'hA0, 1'b0);
        insert(30'h21, 8'h2, 28'hA1, 1'b1);
        step(1'b0, 1'b0, 1'b1, 1'b0, 30'h0, 8'h0, 28'h0, 1'b0);
        expect_miss("R5 non-global cleared", 30'h20, 8'h2);
        expect_hit("R5 global kept", 30'h21, 8'h2, 6'd4, 28'hA1);
    endtask

    task automatic t_flush_all();
        step(1'b0, 1'b0, 1'b0, 1'b1, 30'h0, 8'h0, 28'h0, 1'b0);
        expect_miss("R4 global cleared", 30'h21, 8'h2);
        insert(30'h30, 8'h2, 28'hB0, 1'b0);
        expect_hit("R4 pointer back to 0", 30'h30, 8'h2, 6'd0, 28'hB0);
    endtask

    task automatic t_wrap();
        step(1'b0, 1'b0, 1'b0, 1'b1, 30'h0, 8'h0, 28'h0, 1'b0);
        for (int i = 0; i < DEPTH; i++) insert(30'h100 + 30'(i), 8'h5, 28'h200 + 28'(i), 1'b0);
        expect_hit("R7 last slot", 30'h100 + 30'(DEPTH - 1), 8'h5, 6'(DEPTH - 1),
                   28'h200 + 28'(DEPTH - 1));
        insert(30'h500, 8'h5, 28'h3FF, 1'b0);
        expect_hit("R7 wrapped to 0", 30'h500, 8'h5, 6'd0, 28'h3FF);
        expect_miss("R7 slot 0 overwritten", 30'h100, 8'h5);
        expect_hit("R7 slot 1 intact", 30'h101, 8'h5, 6'd1, 28'h201);
    endtask

    task automatic t_priority();
        step(1'b0, 1'b0, 1'b0, 1'b1, 30'h0, 8'h0, 28'h0, 1'b0);
        insert(30'h40, 8'h1, 28'hC0, 1'b0);
        step(1'b1, 1'b0, 1'b0, 1'b1, 30'h41, 8'h1, 28'hC1, 1'b0);
        expect_miss("R9 flush_all beats insert", 30'h41, 8'h1);
        expect_miss("R9 flush_all applied", 30'h40, 8'h1);
        insert(30'h42, 8'h1, 28'hC2, 1'b0);
        expect_hit("R9 ptr reset by winning flush", 30'h42, 8'h1, 6'd0, 28'hC2);
        step(1'b1, 1'b1, 1'b0, 1'b0, 30'h42, 8'h1, 28'hC3, 1'b0);
        expect_miss("R9 flush_one beats insert", 30'h42, 8'h1);
        insert(30'h43, 8'h1, 28'hC4, 1'b0);
        expect_hit("R9 dropped insert kept pointer", 30'h43, 8'h1, 6'd1, 28'hC4);
        step(1'b0, 1'b1, 1'b1, 1'b0, 30'h50, 8'h1, 28'h0, 1'b0);
        expect_miss("R9 flush_ng beats flush_one", 30'h43, 8'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_global();
        t_dup();
        t_flush_one();
        t_flush_ng();
        t_flush_all();
        t_wrap();
        t_priority();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule